// File: doc/BRIEF.md
# Interval Timer Bus Front End

This block sits between an 8-bit processor-style bus and three counting channels of an interval timer. It has a 2-bit address and separate write and read strobes. Addresses 0 to 2 select a channel's count byte and address 3 is the command register. The block decodes command bytes and holds a captured count and a captured status byte per channel. It steps through single-byte and two-byte access for both loads and reads. Each channel receives a finished 16-bit load value with a one-cycle strobe, together with its counting mode and its decimal-count select.

The counting engines are outside this block. They feed back each channel's live 16-bit count and its output level. Reads return the first available of three sources: a pending status capture, then a pending count capture, then the live count. A read of the command address returns zero. Read data is registered, so it is valid from the clock edge that samples the read strobe.

Top module: `tmr_port`

## Requirements
- R1: After reset every channel has mode 0, decimal select 0 and low-byte-only access, with its no-count-loaded flag set. Read data is 0 and no load strobe is active.
- R2: A command byte at address 3 with bits 7:6 equal to n (0..2) and bits 5:4 non-zero does three things from the next cycle. It sets channel n's access mode from bits 5:4 (01 low only, 10 high only, 11 low then high). It sets the mode output from bits 3:1, where 6 becomes 2 and 7 becomes 3. It sets the decimal select output from bit 0.
- R3: In low-only mode, a data write to a channel's address pulses that channel's load strobe for one cycle in the next cycle, with value {8'h00, byte}. In high-only mode the value is {byte, 8'h00}. At most one load strobe is high at a time, and only after a data write.
- R4: In two-byte mode the first data write produces no load. The second write loads {second byte, first byte}.
- R5: With no capture pending, a read returns the live count. Low-only mode returns the low byte and high-only mode returns the high byte. Two-byte mode alternates low byte, then high byte.
- R6: A command with bits 5:4 equal to 00 captures channel n's live count. The capture is read using the access mode: one byte, or low then high. After that it is released. A further count capture request is ignored while an earlier one is unread.
- R7: A command with bits 7:6 equal to 11 is a read-back. Bit n+1 selects channel n. For every selected channel, bit 5 low requests a count capture and bit 4 low requests a status capture.
- R8: The status byte is {OUT, no-count-loaded, access[1:0], mode[2:0], decimal}. The no-count-loaded bit is set by a mode command and cleared by a completed load.
- R9: A read returns a pending status capture first, then a pending count capture, then the live count.
- R10: A read of address 3 returns 8'h00.
- R11: A mode command returns the channel's read and write byte sequencers to the low byte.
- R12: A status capture request is ignored while an earlier status capture is unread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | 0..2 channel data, 3 command |
| wr | input | 1 | Write strobe, one cycle per byte |
| rd | input | 1 | Read strobe, one cycle per byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| live_cnt | input | 48 | Live counts, channel n at bits 16n+15:16n |
| out_in | input | 3 | Channel output levels |
| mode_o | output | 9 | Counting mode, channel n at bits 3n+2:3n |
| bcd_o | output | 3 | Decimal count select per channel |
| load_o | output | 3 | One-cycle count load strobe per channel |
| load_val | output | 48 | Load value, channel n at bits 16n+15:16n |

## Verification
Every result appears one clock edge after the strobe that causes it. Read data, load strobes and values, mode outputs and decimal-select outputs are all registered at the edge that samples the request. Each bench task drives a strobe on a falling edge and samples the outputs on the following falling edge, which is half a cycle after the edge that captured the request. The live count and OUT inputs are held steady around every read, so each returned byte matches a value the bench chose.

// File: rtl/tmr_port.sv
module tmr_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  addr,
  input  logic        wr,
  input  logic        rd,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic [47:0] live_cnt,
  input  logic [2:0]  out_in,
  output logic [8:0]  mode_o,
  output logic [2:0]  bcd_o,
  output logic [2:0]  load_o,
  output logic [47:0] load_val
);
  logic       is_cmd, rb;
  logic [7:0] rbyte [0:3];

  assign is_cmd   = (addr == 2'd3);
  assign rb       = wr && is_cmd && (wdata[7:6] == 2'b11);
  assign rbyte[3] = 8'h00;

  for (genvar i = 0; i < 3; i++) begin : g_ch
    logic [1:0]  acc, cl;
    logic [2:0]  md;
    logic        bcd, nul, wr_hi, rd_hi, st_lat, ld;
    logic [15:0] cval, lv;
    logic [7:0]  wl, st;
    logic [15:0] live;
    logic        sel_w, sel_r, cw, cw_prog, lat_c, lat_s;
    logic [2:0]  md_in;

    assign live    = live_cnt[16*i +: 16];
    assign sel_w   = wr && (addr == 2'(i));
    assign sel_r   = rd && (addr == 2'(i));
    assign cw      = wr && is_cmd && (wdata[7:6] == 2'(i));
    assign cw_prog = cw && (wdata[5:4] != 2'b00);
    assign lat_c   = (cw && wdata[5:4] == 2'b00) || (rb && wdata[i+1] && !wdata[5]);
    assign lat_s   = rb && wdata[i+1] && !wdata[4];
    assign md_in   = (wdata[3:1] > 3'd5) ? wdata[3:1] - 3'd4 : wdata[3:1];

    assign rbyte[i] = st_lat         ? st :
                      (cl == 2'd1)   ? cval[7:0] :
                      (cl == 2'd2)   ? cval[15:8] :
                      (cl == 2'd3)   ? cval[7:0] :
                      (acc == 2'd2)  ? live[15:8] :
                      (acc == 2'd3 && rd_hi) ? live[15:8] : live[7:0];

    assign mode_o[3*i +: 3]    = md;
    assign bcd_o[i]            = bcd;
    assign load_o[i]           = ld;
    assign load_val[16*i +: 16] = lv;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc <= 2'd1; md <= 3'd0; bcd <= 1'b0; nul <= 1'b1;
        wr_hi <= 1'b0; rd_hi <= 1'b0; st_lat <= 1'b0; cl <= 2'd0;
        cval <= 16'h0; wl <= 8'h0; st <= 8'h0; ld <= 1'b0; lv <= 16'h0;
      end else begin
        ld <= 1'b0;
        if (sel_r) begin
          if (st_lat)             st_lat <= 1'b0;
          else if (cl != 2'd0)    cl <= (cl == 2'd3) ? 2'd2 : 2'd0;
          else if (acc == 2'd3)   rd_hi <= !rd_hi;
        end
        if (lat_c && cl == 2'd0) begin
          cl   <= acc;
          cval <= live;
        end
        if (lat_s && !st_lat) begin
          st_lat <= 1'b1;
          st     <= {out_in[i], nul, acc, md, bcd};
        end
        if (cw_prog) begin
          acc <= wdata[5:4]; md <= md_in; bcd <= wdata[0];
          nul <= 1'b1; wr_hi <= 1'b0; rd_hi <= 1'b0;
        end
        if (sel_w) begin
          case (acc)
            2'd1: begin ld <= 1'b1; lv <= {8'h00, wdata}; nul <= 1'b0; end
            2'd2: begin ld <= 1'b1; lv <= {wdata, 8'h00}; nul <= 1'b0; end
            default: begin
              if (!wr_hi) begin
                wl <= wdata; wr_hi <= 1'b1;
              end else begin
                ld <= 1'b1; lv <= {wdata, wl}; nul <= 1'b0; wr_hi <= 1'b0;
              end
            end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= 8'h00;
    else if (rd) rdata <= rbyte[addr];
  end
endmodule

// File: rtl/tmr_port_chk.sv
module tmr_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  addr,
  input logic        wr,
  input logic        rd,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic [8:0]  mode_o,
  input logic [2:0]  bcd_o,
  input logic [2:0]  load_o
);
  // R3
  load_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o != 3'b000) |-> ($past(wr) && $past(addr) != 2'd3));

  // R3
  load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_o));

  // R10
  cmd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == 2'd3) |=> (rdata == 8'h00));

  // R2
  bcd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd3 && wdata[7:6] == 2'b00 && wdata[5:4] != 2'b00)
      |=> (bcd_o[0] == $past(wdata[0])));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == 2'd3) |=> $stable(mode_o));
endmodule

bind tmr_port tmr_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd), .wdata(wdata),
  .rdata(rdata), .mode_o(mode_o), .bcd_o(bcd_o), .load_o(load_o)
);

// File: tb/tb_tmr_port.sv
`timescale 1ns/1ps
module tb_tmr_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [47:0] live_cnt = 48'h0;
  logic [2:0]  out_in = 3'b000;
  logic [8:0]  mode_o;
  logic [2:0]  bcd_o, load_o;
  logic [47:0] load_val;

  int total = 0, bad = 0;
  logic [2:0]  got_ld;
  logic [47:0] got_val;
  logic [7:0]  got_rd;

  always #5 clk = ~clk;

  tmr_port dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd),
    .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt), .out_in(out_in),
    .mode_o(mode_o), .bcd_o(bcd_o), .load_o(load_o), .load_val(load_val));

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; got_ld = load_o; got_val = load_val;
  endtask

  task automatic rd_byte(input logic [1:0] a);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; got_rd = rdata;
  endtask

  task automatic t_reset;
    check("R1 mode", {39'h0, mode_o}, 48'h0);
    check("R1 bcd", {45'h0, bcd_o}, 48'h0);
    check("R1 load", {45'h0, load_o}, 48'h0);
    check("R1 rdata", {40'h0, rdata}, 48'h0);
    live_cnt[15:0] = 16'h1234;
    wr_byte(2'd3, 8'hE2);
    rd_byte(2'd0); check("R1 status null", {40'h0, got_rd}, 48'h50);
    rd_byte(2'd0); check("R1 live low", {40'h0, got_rd}, 48'h34);
  endtask

  task automatic t_mode;
    wr_byte(2'd3, 8'h3F);
    check("R2 mode fold ch0", {45'h0, mode_o[2:0]}, 48'd3);
    check("R2 bcd ch0", {47'h0, bcd_o[0]}, 48'd1);
    wr_byte(2'd3, 8'h7A);
    check("R2 mode ch1", {45'h0, mode_o[5:3]}, 48'd5);
  endtask

  task automatic t_word_write;
    wr_byte(2'd0, 8'hCD); check("R4 first byte no load", {45'h0, got_ld}, 48'h0);
    wr_byte(2'd0, 8'hAB); check("R4 load strobe", {45'h0, got_ld}, 48'h1);
    check("R4 load value", {32'h0, got_val[15:0]}, 48'hABCD);
  endtask

  task automatic t_byte_write;
    wr_byte(2'd3, 8'h50);
    wr_byte(2'd1, 8'h5A); check("R3 low only strobe", {45'h0, got_ld}, 48'h2);
    check("R3 low only value", {32'h0, got_val[31:16]}, 48'h005A);
    wr_byte(2'd3, 8'h60);
    wr_byte(2'd1, 8'h5A); check("R3 high only value", {32'h0, got_val[31:16]}, 48'h5A00);
  endtask

  task automatic t_live_seq;
    wr_byte(2'd3, 8'hB4);
    live_cnt[47:32] = 16'hBEEF;
    rd_byte(2'd2); check("R5 live low", {40'h0, got_rd}, 48'hEF);
    rd_byte(2'd2); check("R5 live high", {40'h0, got_rd}, 48'hBE);
    rd_byte(2'd2); check("R5 live low again", {40'h0, got_rd}, 48'hEF);
    wr_byte(2'd3, 8'hB4);
    rd_byte(2'd2); check("R11 read seq reset", {40'h0, got_rd}, 48'hEF);
    wr_byte(2'd2, 8'h11);
    wr_byte(2'd3, 8'hB4);
    wr_byte(2'd2, 8'h22); check("R11 write seq reset", {45'h0, got_ld}, 48'h0);
    wr_byte(2'd2, 8'h33); check("R11 load after reset", {32'h0, got_val[47:32]}, 48'h3322);
  endtask

  task automatic t_count_latch;
    live_cnt[15:0] = 16'h1357;
    wr_byte(2'd3, 8'h00);
    live_cnt[15:0] = 16'h2468;
    wr_byte(2'd3, 8'h00);
    rd_byte(2'd0); check("R6 latched low", {40'h0, got_rd}, 48'h57);
    rd_byte(2'd0); check("R6 latched high, repeat ignored", {40'h0, got_rd}, 48'h13);
    rd_byte(2'd0); check("R6 released low", {40'h0, got_rd}, 48'h68);
    rd_byte(2'd0); check("R6 released high", {40'h0, got_rd}, 48'h24);
  endtask

  task automatic t_status;
    out_in[1] = 1'b1;
    live_cnt[31:16] = 16'h7700;
    wr_byte(2'd3, 8'hE4);
    out_in[1] = 1'b0;
    wr_byte(2'd3, 8'hE4);
    rd_byte(2'd1); check("R12 status kept", {40'h0, got_rd}, 48'hA0);
    rd_byte(2'd1); check("R7 status only then live", {40'h0, got_rd}, 48'h77);
  endtask

  task automatic t_priority;
    live_cnt[47:32] = 16'hBEEF;
    out_in[2] = 1'b0;
    wr_byte(2'd3, 8'hC8);
    live_cnt[47:32] = 16'h4321;
    rd_byte(2'd2); check("R9 status first", {40'h0, got_rd}, 48'h34);
    rd_byte(2'd2); check("R9 count low", {40'h0, got_rd}, 48'hEF);
    rd_byte(2'd2); check("R9 count high", {40'h0, got_rd}, 48'hBE);
    rd_byte(2'd2); check("R9 live low", {40'h0, got_rd}, 48'h21);
    rd_byte(2'd2); check("R9 live high", {40'h0, got_rd}, 48'h43);
  endtask

  task automatic t_null;
    out_in[0] = 1'b1;
    wr_byte(2'd3, 8'h30);
    wr_byte(2'd3, 8'hE2);
    rd_byte(2'd0); check("R8 null set", {40'h0, got_rd}, 48'hF0);
    wr_byte(2'd0, 8'h01);
    wr_byte(2'd0, 8'h02);
    wr_byte(2'd3, 8'hE2);
    rd_byte(2'd0); check("R8 null cleared", {40'h0, got_rd}, 48'hB0);
  endtask

  task automatic t_cmd_read;
    rd_byte(2'd3); check("R10 command read", {40'h0, got_rd}, 48'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode();
    t_word_write();
    t_byte_write();
    t_live_seq();
    t_count_latch();
    t_status();
    t_priority();
    t_null();
    t_cmd_read();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule